// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned W-bit operands and returns their full 2W-bit product. It is built as a grid of identical cells. Each cell ANDs one multiplicand bit with one multiplier bit and adds that bit into a running sum through a full adder. One row of cells handles one multiplier bit, and a register bank closes every row. A new operand pair can therefore enter on every clock edge while earlier pairs are still moving through the grid.

Each row stage carries the multiplicand and multiplier forward in skew registers next to its partial sum, so every operand pair stays aligned with its own sum. The carries of a row ripple across that row inside its stage, so each row's register holds a fully resolved binary value. A final output register presents the product together with a valid flag.

The valid flags use an asynchronous active-low reset. The integrator is expected to release that reset in step with the clock. Datapath registers are not reset, and they load only when their stage carries a valid pair.

Top module: `amul_pipe`

## Requirements
- R1: For every accepted pair, out_p equals the unsigned product in_a * in_x, written as 2W bits.
- R2: Latency is constant. A pair sampled on a rising edge appears on out_p with out_valid high after W+1 rising edges, counting the sampling edge itself. With W=5 this is 6 edges.
- R3: A pair is accepted on every edge where in_valid is high, including back-to-back edges. Results leave one per cycle, in the order the pairs were accepted.
- R4: out_valid is high only on the cycle W+1 edges after an accepted pair. Gaps in the input stream reappear unchanged at the output.
- R5: Driving rst_n low clears every valid flag at once and drops any pair in flight. out_valid stays low until a pair accepted after reset reaches the output.
- R6: in_a and in_x have no effect while in_valid is low. While out_valid is low, out_p holds the last product it presented.
- R7: Multiplier bit j adds in_a shifted left by j places. After row stage j, the running sum equals the sum of rows 0 to j and is below 2^(W+j+1).
- R8: Corner operands give exact results: 0*0 is 0, (2^W-1)*(2^W-1) is 2^(2W)-2^(W+1)+1 (961 for W=5), and 1*(2^W-1) is 2^W-1.
- R9: A valid out_p never exceeds (2^W-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset for the valid flags, asserted asynchronously |
| in_valid | input | 1 | Marks in_a and in_x as an operand pair to multiply |
| in_a | input | W | Unsigned multiplicand |
| in_x | input | W | Unsigned multiplier |
| out_valid | output | 1 | Marks out_p as a fresh product |
| out_p | output | 2W | Unsigned product |

## Verification
Several properties are checked on every cycle:
- Each row stage's registered sum is the previous sum plus its own shifted partial-product row, and it fits its width bound.
- The output register matches the product of the operands that travelled with it.
- A valid product never exceeds the largest possible product.
- out_valid never rises with nothing in flight, and the in-flight count never exceeds the pipeline depth.

Only the bench scenarios can show the end-to-end behaviour:
- The exact output cycle for each pair.
- Preserved ordering under back-to-back and gapped streams.
- The dropping of in-flight pairs on a mid-stream reset.
- The holding of out_p across idle cycles with changing, unqualified operands.

// File: rtl/amul_pkg.sv
package amul_pkg;

  // Pipeline depth: one register bank per multiplier bit plus the output bank.
  function automatic int amul_latency(input int width);
    return width + 1;
  endfunction

  // Width of the in-flight counter needed to hold the values 0 to depth.
  function automatic int amul_count_width(input int width);
    return $clog2(width + 2) + 1;
  endfunction

endpackage

// File: rtl/amul_cell.sv
// One grid cell: partial-product bit followed by a full adder.
module amul_cell (
  input  logic a_bit,
  input  logic x_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);

  logic pp_bit;

  assign pp_bit    = a_bit & x_bit;
  assign sum_out   = pp_bit ^ sum_in ^ carry_in;
  assign carry_out = (pp_bit & sum_in) | (pp_bit & carry_in) | (sum_in & carry_in);

endmodule

// File: rtl/amul_stage.sv
// One row of cells for multiplier bit ROW, closed by a register bank.
module amul_stage #(
  parameter int unsigned W   = 5,
  parameter int unsigned ROW = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            v_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    x_i,
  input  logic [2*W-1:0]  ps_i,
  output logic            v_o,
  output logic [W-1:0]    a_o,
  output logic [W-1:0]    x_o,
  output logic [2*W-1:0]  ps_o
);

  localparam int unsigned PW  = 2 * W;
  localparam int unsigned TOP = ROW + W;   // bit that receives the row carry-out

  logic [W:0]    cy;
  logic [W-1:0]  sm;
  logic [PW-1:0] ps_d;
  logic          v_q;
  logic [W-1:0]  a_q;
  logic [W-1:0]  x_q;
  logic [PW-1:0] ps_q;

  assign cy[0] = 1'b0;

  // Carries ripple across the row, cell m to cell m+1.
  for (genvar m = 0; m < W; m++) begin : g_cell
    amul_cell u_cell (
      .a_bit     (a_i[m]),
      .x_bit     (x_i[ROW]),
      .sum_in    (ps_i[ROW+m]),
      .carry_in  (cy[m]),
      .sum_out   (sm[m]),
      .carry_out (cy[m+1])
    );
  end

  // Next-state: low bits pass through, row bits replaced, carry lands on TOP.
  always_comb begin
    ps_d             = ps_i;
    ps_d[ROW +: W]   = sm;
    ps_d[TOP]        = cy[W];
  end

  // Valid flag: asynchronous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= v_i;
    end
  end

  // Datapath and skew registers: load only with a valid pair.
  always_ff @(posedge clk) begin
    if (v_i) begin
      a_q  <= a_i;
      x_q  <= x_i;
      ps_q <= ps_d;
    end
  end

  assign v_o  = v_q;
  assign a_o  = a_q;
  assign x_o  = x_q;
  assign ps_o = ps_q;

  AST_ROW_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> ps_o == $past(ps_i + ((PW'(a_i) & {PW{x_i[ROW]}}) << ROW)))
    else $error("row sum mismatch");  // R7

  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (ps_o >> (W + ROW + 1)) == '0)
    else $error("row sum too wide");  // R7

endmodule

// File: rtl/amul_pipe.sv
module amul_pipe #(
  parameter int unsigned W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_x,
  output logic           out_valid,
  output logic [2*W-1:0] out_p
);

  localparam int unsigned PW  = 2 * W;
  localparam int unsigned LAT = amul_pkg::amul_latency(W);
  localparam int unsigned CW  = amul_pkg::amul_count_width(W);
  localparam logic [W-1:0]  OPMAX = '1;
  localparam logic [PW-1:0] PMAX  = PW'(OPMAX) * PW'(OPMAX);

  logic            v_pipe  [0:W];
  logic [W-1:0]    a_pipe  [0:W];
  logic [W-1:0]    x_pipe  [0:W];
  logic [PW-1:0]   ps_pipe [0:W];

  assign v_pipe[0]  = in_valid;
  assign a_pipe[0]  = in_a;
  assign x_pipe[0]  = in_x;
  assign ps_pipe[0] = '0;

  for (genvar j = 0; j < W; j++) begin : g_row
    amul_stage #(.W(W), .ROW(j)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (v_pipe[j]),
      .a_i   (a_pipe[j]),
      .x_i   (x_pipe[j]),
      .ps_i  (ps_pipe[j]),
      .v_o   (v_pipe[j+1]),
      .a_o   (a_pipe[j+1]),
      .x_o   (x_pipe[j+1]),
      .ps_o  (ps_pipe[j+1])
    );
  end

  // Output bank.
  logic          ov_d, ov_q;
  logic [PW-1:0] op_d, op_q;

  always_comb begin
    ov_d = v_pipe[W];
    op_d = v_pipe[W] ? ps_pipe[W] : op_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
    end
  end

  always_ff @(posedge clk) begin
    op_q <= op_d;
  end

  assign out_valid = ov_q;
  assign out_p     = op_q;

  // In-flight count: pairs held anywhere in the row banks or the output bank.
  logic [CW-1:0] inflight_d, inflight_q;

  always_comb begin
    inflight_d = inflight_q + CW'(in_valid) - CW'(ov_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= '0;
    end else begin
      inflight_q <= inflight_d;
    end
  end

  AST_OUT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_p == PW'($past(a_pipe[W])) * PW'($past(x_pipe[W])))
    else $error("product mismatch");  // R1

  AST_OUT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_p <= PMAX)
    else $error("product above maximum");  // R9

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight_q != '0)
    else $error("valid with nothing in flight");  // R4

  AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CW'(LAT))
    else $error("more pairs in flight than stages");  // R3

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!out_valid) else $error("valid during reset");  // R5
    end
  end

endmodule

// File: tb/sim_amul_pipe.sv
module sim_amul_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 5;
  localparam int PW  = 2 * W;
  localparam int LAT = W + 1;
  localparam int NV  = 16;
  localparam logic [PW-1:0] PMAX = 10'd961;

  // {a, x, expected p}
  localparam logic [19:0] VEC [NV] = '{
    {5'd0,  5'd0,  10'd0},   {5'd31, 5'd31, 10'd961},
    {5'd1,  5'd31, 10'd31},  {5'd31, 5'd1,  10'd31},
    {5'd13, 5'd11, 10'd143}, {5'd5,  5'd7,  10'd35},
    {5'd16, 5'd16, 10'd256}, {5'd30, 5'd29, 10'd870},
    {5'd17, 5'd3,  10'd51},  {5'd9,  5'd27, 10'd243},
    {5'd31, 5'd0,  10'd0},   {5'd2,  5'd15, 10'd30},
    {5'd22, 5'd25, 10'd550}, {5'd7,  5'd19, 10'd133},
    {5'd24, 5'd31, 10'd744}, {5'd1,  5'd1,  10'd1}
  };

  typedef struct {
    int            tgt;
    logic [PW-1:0] p;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  in_a, in_x;
  logic          out_valid;
  logic [PW-1:0] out_p;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   have_last = 0;
  bit   post_rst = 0;
  logic [PW-1:0] last_p;
  exp_t q[$];

  amul_pipe #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_x(in_x),
    .out_valid(out_valid), .out_p(out_p)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Monitor: samples 1 time unit after each rising edge.
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      check(out_valid == 1'b0, "R5", "out_valid in reset", out_valid, 0);
    end else if (out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, post_rst ? "R5" : "R4", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.tgt, "R2", "output cycle", cyc, e.tgt);
        check(out_p == e.p, e.req, "product", out_p, e.p);
        check(out_p <= PMAX, "R9", "product bound", out_p, PMAX);
        last_p = out_p;
        have_last = 1;
      end
    end else begin
      if (q.size() > 0 && q[0].tgt <= cyc) begin
        check(1'b0, "R4", "missing out_valid", 0, 1);
        void'(q.pop_front());
      end
      if (have_last) check(out_p == last_p, "R6", "out_p hold", out_p, last_p);
    end
  end

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] x,
                      input logic [PW-1:0] p, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_x = x;
    e.tgt = cyc + LAT;
    e.p = p;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = W'($urandom);
      in_x = W'($urandom);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R2", "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_a = '0;
    in_x = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 table walk, back to back
    for (int i = 0; i < NV; i++) send(VEC[i][19:15], VEC[i][14:10], VEC[i][9:0], "R1");
    idle(LAT + 2);

    // R7 single-row multipliers: x = 1<<j gives a<<j
    for (int j = 0; j < W; j++) send(5'd27, W'(1 << j), PW'(27) << j, "R7");
    idle(LAT + 2);

    // R3 random back-to-back stream
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, x;
      a = W'($urandom);
      x = W'($urandom);
      send(a, x, PW'(a) * PW'(x), "R3");
    end

    // R6 gapped stream with junk operands on idle cycles
    for (int i = 0; i < 60; i++) begin
      if ($urandom % 2) begin
        logic [W-1:0] a, x;
        a = W'($urandom);
        x = W'($urandom);
        send(a, x, PW'(a) * PW'(x), "R6");
      end else begin
        idle(1);
      end
    end
    idle(LAT + 2);

    // R8 corners
    send(5'd0, 5'd0, 10'd0, "R8");
    send(5'd31, 5'd31, 10'd961, "R8");
    send(5'd1, 5'd31, 10'd31, "R8");
    idle(LAT + 2);

    // R5 reset with pairs in flight
    send(5'd3, 5'd4, 10'd12, "R5");
    send(5'd6, 5'd7, 10'd42, "R5");
    send(5'd9, 5'd9, 10'd81, "R5");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    q.delete();
    have_last = 0;
    post_rst = 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(LAT + 3);
    post_rst = 0;
    send(5'd25, 5'd14, 10'd350, "R5");
    idle(LAT + 3);

    check(q.size() == 0, "R2", "queue drained", q.size(), 0);
    summary();
    $finish;
  end

endmodule